// File: doc/BRIEF.md
# Key-Protected Memory Controller Register File

This block is the software-visible configuration space of a DRAM controller. It answers a simple 32-bit register bus (byte address, write enable, read enable, write data, registered read data) and decodes a 4 KiB window as 32-bit words. Only some of those words are backed by physical registers. Word 0 is a protection register: software must write a fixed 32-bit key into it before any other register accepts a write. Any other value written there locks the block again.

Word 1 is the configuration register. A parameter selects one of two controller generations. Each generation has its own set of read-only fields and its own fixed, strap-derived value. That value carries the RAM size code, chosen at build time from a RAM size parameter. Every write to the configuration register clears the read-only fields of the incoming data and then ORs the fixed value into it. The register therefore always reports the size code and the identification bits. The block leaves reset locked.

Reads are never gated by the lock. Each rejected write raises a one-cycle pulse, so that a bench or a bus monitor can see it.

Top module: `memctl_regbank`

## Requirements
- R1: Writing 0xFC600309 to byte address 0x000 makes the protection word read back as 1 (unlocked). Writing any other value there makes it read back as 0 (locked). A write to the protection word is always accepted.
- R2: While locked, a write to any in-bounds word other than word 0 leaves that word's contents unchanged.
- R3: After reset the block is locked (word 0 reads 0), the configuration word reads its fixed value, and every other word reads 0.
- R4: A write to the configuration word (byte address 0x004) stores (data AND NOT mask) OR fixed. The generation-0 mask is 0xFFFFF84C (bits 31:11, bit 6, bits 3:2). The generation-1 mask is 0xF00FC04C (bits 31:28, bits 19:14, bit 6, bits 3:2).
- R5: The size code sits in configuration bits 1:0. Generation 0 codes 64/128/256/512 MiB as 0/1/2/3. Generation 1 codes 128/256/512/1024 MiB as 0/1/2/3. Any other size gives code 2, which is 256 MiB for generation 0 and 512 MiB for generation 1.
- R6: The fixed value is bit 6 OR the size code for generation 0. For generation 1 it is 0x10000000 (version 1) OR 0x00080000 (cache initialisation done) OR 0x0000000C (aperture 3) OR the size code.
- R7: A word index (byte address shifted right by 2) at or beyond NUM_REGS (default 64, so byte address 0x100 and above) reads 0. A write to such an index is ignored even while unlocked and does not alias onto any implemented word.
- R8: rd_valid is high exactly one cycle after rd_en, with rdata for the word addressed by that read. This holds whether the block is locked or not.
- R9: wr_reject pulses high in the cycle after a write that is dropped because the block is locked (R2) or the index is out of bounds (R7). It stays low after an accepted write and in every cycle with no write.
- R10: A read and a write to the same word in the same cycle return the contents from before the write. The written value appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address of the access, word aligned |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| wr_reject | output | 1 | One-cycle pulse after a dropped write |

## Verification
Because the bus allows a read and a write in one cycle, the read mux and the write path can address the same word on the same edge. The bench drives both strobes to one word in one cycle and expects the old contents, then reads again and expects the new data (R10). A dropped write and a read can also overlap in one cycle. The bench judges that case by the wr_reject pulse in the same output cycle and by a later read showing the word unchanged.

// File: rtl/memctl_pkg.sv
// Shared constants and build-time functions for the memory controller
// register file. Assumes 32-bit registers and exactly two generations (0, 1).
package memctl_pkg;

    localparam int unsigned REG_W = 32;
    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

    // Map a RAM size in MiB to the two-bit size code of a generation.
    function automatic logic [1:0] size_code(int unsigned gen, int unsigned mib);
        logic [1:0] code;
        code = 2'd2;
        if (gen == 0) begin
            case (mib)
                64:      code = 2'd0;
                128:     code = 2'd1;
                256:     code = 2'd2;
                512:     code = 2'd3;
                default: code = 2'd2;
            endcase
        end else begin
            case (mib)
                128:     code = 2'd0;
                256:     code = 2'd1;
                512:     code = 2'd2;
                1024:    code = 2'd3;
                default: code = 2'd2;
            endcase
        end
        return code;
    endfunction

    // Read-only field mask of the configuration word for a generation.
    function automatic logic [REG_W-1:0] cfg_mask(int unsigned gen);
        if (gen == 0)
            return 32'hFFFF_F800 | 32'h0000_0040 | 32'h0000_000C;
        else
            return 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000
                 | 32'h0000_0040 | 32'h0000_000C;
    endfunction

    // Fixed strap-derived value ORed into the configuration word.
    function automatic logic [REG_W-1:0] cfg_fixed(int unsigned gen, int unsigned mib);
        logic [REG_W-1:0] v;
        if (gen == 0)
            v = 32'h0000_0040;
        else
            v = 32'h1000_0000 | 32'h0008_0000 | 32'h0000_000C;
        return v | {30'd0, size_code(gen, mib)};
    endfunction

endpackage

// File: rtl/memctl_access_decode.sv
// Address decoder: turns a byte address into a word index and flags whether
// it is backed, the protection word or the configuration word.
// Assumes word-aligned accesses; address bits 1:0 are not used.
module memctl_access_decode #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 64,
    localparam int unsigned WORD_W  = ADDR_W - 2,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_bounds,
    output logic              is_prot,
    output logic              is_cfg
);

    localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(NUM_REGS);

    logic [WORD_W-1:0] word;
    logic              unused_low;

    assign unused_low = ^addr[1:0];

    // Split the address into the word index and its bounds flag.
    always_comb begin
        word      = addr[ADDR_W-1:2];
        in_bounds = ({1'b0, word} < LIMIT);
        idx       = word[IDX_W-1:0];
        is_prot   = in_bounds && (idx == IDX_W'(0));
        is_cfg    = in_bounds && (idx == IDX_W'(1));
    end

endmodule

// File: rtl/memctl_key_gate.sv
// Protection gate: holds the lock flag, updates it on every write to the
// protection word, decides whether a write may land and flags drops.
// Assumes a single write port and a synchronous active-low reset.
module memctl_key_gate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        in_bounds,
    input  logic        is_prot,
    output logic        unlocked,
    output logic        wr_accept,
    output logic        wr_reject
);

    import memctl_pkg::*;

    logic unlocked_q;
    logic reject_q;

    // A write lands on the protection word always, elsewhere only when open.
    always_comb begin
        wr_accept = wr_en && in_bounds && (is_prot || unlocked_q);
    end

    // Lock flag: set by the exact key, cleared by any other protection write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked_q <= 1'b0;
        else if (wr_en && is_prot)
            unlocked_q <= (wdata == UNLOCK_KEY);
    end

    // Drop pulse, one cycle after a write that did not land.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reject_q <= 1'b0;
        else
            reject_q <= wr_en && !wr_accept;
    end

    assign unlocked  = unlocked_q;
    assign wr_reject = reject_q;

endmodule

// File: rtl/memctl_reg_array.sv
// Register storage and read port. Word 0 mirrors the lock flag, word 1 is
// the configuration word with masked, strap-merged writes, the rest are
// plain 32-bit registers. Reads are registered and see pre-write contents.
// Assumes NUM_REGS >= 2 and that wr_accept already includes bounds checks.
module memctl_reg_array #(
    parameter int unsigned GEN      = 1,
    parameter int unsigned RAM_MIB  = 512,
    parameter int unsigned NUM_REGS = 64,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic             rd_en,
    input  logic             in_bounds,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic             unlocked,
    output logic [31:0]      rdata,
    output logic             rd_valid,
    output logic [31:0]      cfg_word
);

    import memctl_pkg::*;

    localparam logic [31:0] CFG_MASK  = cfg_mask(GEN);
    localparam logic [31:0] CFG_FIXED = cfg_fixed(GEN, RAM_MIB);

    logic [31:0] view [NUM_REGS];
    logic [31:0] rdata_q;
    logic        valid_q;

    assign view[0] = {31'd0, unlocked};

    genvar i;
    generate
        for (i = 1; i < NUM_REGS; i++) begin : g_slot
            logic [31:0] q;
            logic        hit;
            assign hit = wr_accept && (idx == IDX_W'(i));
            if (i == 1) begin : g_cfg
                // Configuration word: keep read-only fields, force strap bits.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= CFG_FIXED;
                    else if (hit)
                        q <= (wdata & ~CFG_MASK) | CFG_FIXED;
                end
            end else begin : g_plain
                // Plain word: store the written value.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= 32'd0;
                    else if (hit)
                        q <= wdata;
                end
            end
            assign view[i] = q;
        end
    endgenerate

    // Registered read: one cycle of latency, zero for unbacked indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 32'd0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en;
            if (rd_en)
                rdata_q <= in_bounds ? view[idx] : 32'd0;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = valid_q;
    assign cfg_word = view[1];

endmodule

// File: rtl/memctl_regbank.sv
// Top of the key-protected memory controller register file. Wires the
// address decoder, the protection gate and the storage together.
// Assumes word-aligned 32-bit accesses and at most one write per cycle.
module memctl_regbank #(
    parameter int unsigned GEN      = 1,
    parameter int unsigned RAM_MIB  = 512,
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned ADDR_W   = 12,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              wr_reject
);

    logic [IDX_W-1:0] idx;
    logic             in_bounds;
    logic             is_prot;
    logic             is_cfg;
    logic             unlocked;
    logic             wr_accept;
    logic [31:0]      cfg_word;
    logic             unused_cfg_sel;

    assign unused_cfg_sel = is_cfg;

    memctl_access_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .addr      (addr),
        .idx       (idx),
        .in_bounds (in_bounds),
        .is_prot   (is_prot),
        .is_cfg    (is_cfg)
    );

    memctl_key_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .in_bounds (in_bounds),
        .is_prot   (is_prot),
        .unlocked  (unlocked),
        .wr_accept (wr_accept),
        .wr_reject (wr_reject)
    );

    memctl_reg_array #(
        .GEN      (GEN),
        .RAM_MIB  (RAM_MIB),
        .NUM_REGS (NUM_REGS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .rd_en     (rd_en),
        .in_bounds (in_bounds),
        .idx       (idx),
        .wdata     (wdata),
        .unlocked  (unlocked),
        .rdata     (rdata),
        .rd_valid  (rd_valid),
        .cfg_word  (cfg_word)
    );

endmodule

// File: rtl/memctl_regbank_chk.sv
// Property checker for memctl_regbank, attached to every instance by bind.
// Observes the bus ports, the lock flag and the configuration word.
module memctl_regbank_chk #(
    parameter int unsigned GEN      = 1,
    parameter int unsigned RAM_MIB  = 512,
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              rd_valid,
    input logic              wr_reject,
    input logic              unlocked,
    input logic [31:0]       cfg_word
);

    import memctl_pkg::*;

    localparam logic [31:0] MASK  = cfg_mask(GEN);
    localparam logic [31:0] FIXED = cfg_fixed(GEN, RAM_MIB);

    logic oob;
    logic at_prot;
    assign oob     = (32'(addr[ADDR_W-1:2]) >= NUM_REGS);
    assign at_prot = (addr[ADDR_W-1:2] == '0);

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_prot && wdata == UNLOCK_KEY) |=> unlocked); // R1
    AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_prot && wdata != UNLOCK_KEY) |=> !unlocked); // R1
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && !at_prot && !oob) |=> (wr_reject && $stable(cfg_word))); // R2
    AST_CFG_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (((cfg_word & MASK) == (FIXED & MASK)) && ((cfg_word & FIXED) == FIXED))); // R4
    AST_OOB_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && oob) |=> (rdata == 32'd0)); // R7
    AST_OOB_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && oob) |=> (wr_reject && $stable(cfg_word))); // R7
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R8
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R8
    AST_REJECT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_reject); // R9
    AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !oob && (unlocked || at_prot)) |=> !wr_reject); // R9

endmodule

bind memctl_regbank memctl_regbank_chk #(
    .GEN      (GEN),
    .RAM_MIB  (RAM_MIB),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .wr_reject (wr_reject),
    .unlocked  (unlocked),
    .cfg_word  (cfg_word)
);

// File: tb/memctl_regbank_test.sv
`timescale 1ns/1ps
// Scoreboard bench: two instances (generation 1 at 512 MiB, generation 0 at
// an unsupported 100 MiB) share one bus. The driver queues the expected
// result of each access; the monitor pops and compares one cycle later.
module memctl_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        valid_a, valid_b, rej_a, rej_b;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic        re;
        logic [31:0] ea;
        logic [31:0] eb;
        logic        rej;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    memctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_a), .rd_valid(valid_a), .wr_reject(rej_a)
    );

    memctl_regbank #(.GEN(0), .RAM_MIB(100)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata_b), .rd_valid(valid_b), .wr_reject(rej_b)
    );

    // Drive one bus cycle and queue what both instances must show next.
    task automatic op(input logic [11:0] a, input logic we, input logic re,
                      input logic [31:0] d, input logic [31:0] ea,
                      input logic [31:0] eb, input logic rej, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = we; rd_en = re; wdata = d;
        @(posedge clk);
        it.re = re; it.ea = ea; it.eb = eb; it.rej = rej; it.tag = tag;
        sb.push_back(it);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Monitor: compare outputs half a cycle after the edge that produced them.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            bit bad;
            it = sb.pop_front();
            bad = (valid_a !== it.re) || (valid_b !== it.re)
               || (rej_a !== it.rej) || (rej_b !== it.rej);
            if (it.re)
                bad = bad || (rdata_a !== it.ea) || (rdata_b !== it.eb);
            compared++;
            if (bad) begin
                mismatched++;
                $display("FAIL %s: got rd=%h/%h v=%b/%b rej=%b/%b exp rd=%h/%h v=%b rej=%b",
                         it.tag, rdata_a, rdata_b, valid_a, valid_b, rej_a, rej_b,
                         it.ea, it.eb, it.re, it.rej);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state
        op(12'h000, 0, 0, 0, 0, 0, 0, "R3 idle after reset");
        op(12'h000, 0, 1, 0, 0, 0, 0, "R3 locked after reset");
        op(12'h004, 0, 1, 0, 32'h1008_000E, 32'h0000_0042, 0, "R3 R5 R6 cfg reset value");
        op(12'h008, 0, 1, 0, 0, 0, 0, "R3 plain word zero");
        // R2 locked writes dropped
        op(12'h008, 1, 0, 32'h1234_5678, 0, 0, 1, "R2 R9 locked write rejected");
        op(12'h008, 0, 1, 0, 0, 0, 0, "R2 locked word unchanged");
        op(12'h004, 1, 1, 32'hFFFF_FFFF, 32'h1008_000E, 32'h0000_0042, 1, "R2 R9 locked cfg write with read");
        op(12'h004, 0, 1, 0, 32'h1008_000E, 32'h0000_0042, 0, "R2 cfg unchanged");
        // R1 key handling
        op(12'h000, 1, 0, 32'hFC60_0308, 0, 0, 0, "R1 R9 wrong key accepted as write");
        op(12'h000, 0, 1, 0, 0, 0, 0, "R1 wrong key stays locked");
        op(12'h000, 1, 0, 32'hFC60_0309, 0, 0, 0, "R1 R9 key write no reject");
        op(12'h000, 0, 1, 0, 1, 1, 0, "R1 unlocked reads 1");
        op(12'h008, 1, 0, 32'h1234_5678, 0, 0, 0, "R9 accepted write quiet");
        op(12'h008, 0, 1, 0, 32'h1234_5678, 32'h1234_5678, 0, "R2 unlocked write lands");
        // R4 configuration merge
        op(12'h004, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, "R4 cfg all ones");
        op(12'h004, 0, 1, 0, 32'h1FF8_3FBF, 32'h0000_07F3, 0, "R4 cfg all ones merged");
        op(12'h004, 1, 0, 32'h0000_0000, 0, 0, 0, "R4 cfg zeros");
        op(12'h004, 0, 1, 0, 32'h1008_000E, 32'h0000_0042, 0, "R4 R6 cfg zeros keep fixed");
        op(12'h004, 1, 0, 32'hA5A5_A5A5, 0, 0, 0, "R4 cfg pattern");
        op(12'h004, 0, 1, 0, 32'h15A8_25AF, 32'h0000_05E3, 0, "R4 cfg pattern merged");
        // R7 out of bounds
        op(12'h104, 1, 0, 32'h0000_0000, 0, 0, 1, "R7 R9 oob write rejected");
        op(12'h004, 0, 1, 0, 32'h15A8_25AF, 32'h0000_05E3, 0, "R7 oob write no alias to cfg");
        op(12'h100, 1, 0, 32'hFFFF_FFFF, 0, 0, 1, "R7 oob write at first unbacked");
        op(12'h000, 0, 1, 0, 1, 1, 0, "R7 oob no alias to protection");
        op(12'h100, 0, 1, 0, 0, 0, 0, "R7 oob read first unbacked");
        op(12'hFFC, 0, 1, 0, 0, 0, 0, "R7 oob read window top");
        op(12'h0FC, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, "R7 last backed write");
        op(12'h0FC, 0, 1, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, "R7 last backed readback");
        // R10 same-cycle read and write
        op(12'h00C, 1, 1, 32'hCAFE_F00D, 0, 0, 0, "R10 collision returns old");
        op(12'h00C, 0, 1, 0, 32'hCAFE_F00D, 32'hCAFE_F00D, 0, "R10 new value next read");
        // R8 reads while locked, relock by wrong value
        op(12'h000, 1, 0, 32'h0000_0000, 0, 0, 0, "R1 relock");
        op(12'h008, 0, 1, 0, 32'h1234_5678, 32'h1234_5678, 0, "R8 read ungated when locked");
        op(12'h008, 1, 1, 32'h0BAD_0BAD, 32'h1234_5678, 32'h1234_5678, 1, "R8 R2 read with dropped write");
        op(12'h008, 0, 1, 0, 32'h1234_5678, 32'h1234_5678, 0, "R2 relocked word unchanged");
        op(12'h008, 0, 0, 0, 0, 0, 0, "R8 R9 idle no valid no reject");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule